// File: doc/BRIEF.md
# Address-Masked GPIO Register Controller

This block is an eight-pin general-purpose I/O controller behind a simple memory-mapped register port covering a 4 KB offset window. A single-cycle write strobe with address and data updates registers on the rising clock edge. Read data is a combinational function of the address and the current register state. Every access below offset 0x400 reaches the pin data register. For those accesses the word-address bits act as a per-bit enable, so software can read or change any subset of pins with one access and no read-modify-write.

Each pin is either an input or an output, chosen by a direction register. Output pins drive their data bit, and input pins float their output high. Inputs pass through a synchronizer before they update the data register and before they reach per-pin interrupt detection. Detection can be level or edge sensitive, and the combined interrupt line is the OR of the enabled status bits.

A bank of pad-configuration registers is held for a neighbouring pad ring. The alternate-function selection can only change in bits that a commit register allows. The commit register itself can only be rewritten while a key-protected lock is open. Twelve read-only identification bytes sit at the top of the window.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset the lock register reads 1, the commit register reads 0xFF, and every other register reads 0. `pin_out` is all ones and `irq` is 0.
- R2: A read at any offset below 0x400 returns the data register ANDed with offset bits [9:2]. Bit k of that field enables pin k.
- R3: A write at an offset below 0x400 changes only the data bits whose offset bit [k+2] is 1 and whose pin is an output. All other data bits keep their value.
- R4: The direction register is at 0x400, and a 1 makes the pin an output. The data bit of an input pin follows `pin_in` through a two-flop synchronizer and can be read on the third clock edge after the change.
- R5: Each `pin_out` bit equals the data bit for an output pin and 1 for an input pin. `pin_out` changes only in the cycle after a write to the data window or to the direction register.
- R6: Interrupt configuration is held at these offsets: 0x404 sense, 0x408 both-edges, 0x40C event, 0x410 mask. Raw status reads at 0x414, and masked status at 0x418 reads raw AND mask. `irq` is the OR of the masked status bits.
- R7: With sense bit 0, an input pin sets its raw bit on an edge of the synchronized level. If the both-edges bit is 1, either edge sets it. Otherwise event 1 selects a rising edge and event 0 a falling edge. Output pins never set raw bits.
- R8: With sense bit 1, an input pin sets its raw bit on every cycle in which the synchronized level equals its event bit. When a set and a clear arrive in the same cycle, the set wins.
- R9: Writing to 0x41C clears every raw status bit whose write-data bit is 1.
- R10: The pad registers are at 0x500, 0x504, 0x508, 0x50C, 0x510, 0x514, 0x518, 0x51C and 0x528. They are writable and readable, and only the low 8 data bits are stored.
- R11: A write of 0x0ACCE551 to 0x520 opens the lock, and any other value written there closes it. A read of 0x520 returns 1 when closed and 0 when open. A write to the commit register at 0x524 takes effect only while the lock is open.
- R12: A write to the alternate-function register at 0x420 updates only the bits that are 1 in the commit register.
- R13: Reads of offsets 0xFD0 to 0xFFC return one identification byte per word, in the sequence 0x00,0x00,0x00,0x00,0x61,0x10,0x04,0x00,0x0D,0xF0,0x05,0xB1.
- R14: Any other offset, including unaligned offsets at or above 0x400, reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | External pin levels, asynchronous |
| pin_out | output | NPINS | Resolved pin drive values |
| irq | output | 1 | Combined interrupt, OR of masked status |

## Verification
On every cycle the assertions check four things:
- Data writes leave unmasked output bits and all input bits alone.
- Output-pin status bits never rise.
- Commit and alternate-function updates respect the lock and the commit mask.
- `pin_out` moves only after a data or direction write.

Only the bench scenarios can show the read-side behaviour: the masked data view, the identification sequence, zero reads at undefined offsets, and the correct kind of edge or level setting each status bit after the synchronizer delay. The randomized phase mixes direction flips with masked writes while the inputs change, so it covers a pin that turns from input to output and keeps its last sampled value.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
   localparam int unsigned OFF_W = 12;

   localparam logic [OFF_W-1:0] OFF_DIR    = 12'h400;
   localparam logic [OFF_W-1:0] OFF_SENSE  = 12'h404;
   localparam logic [OFF_W-1:0] OFF_BOTH   = 12'h408;
   localparam logic [OFF_W-1:0] OFF_EVT    = 12'h40C;
   localparam logic [OFF_W-1:0] OFF_MASK   = 12'h410;
   localparam logic [OFF_W-1:0] OFF_RAW    = 12'h414;
   localparam logic [OFF_W-1:0] OFF_MSTAT  = 12'h418;
   localparam logic [OFF_W-1:0] OFF_CLR    = 12'h41C;
   localparam logic [OFF_W-1:0] OFF_ALT    = 12'h420;
   localparam logic [OFF_W-1:0] OFF_LOCK   = 12'h520;
   localparam logic [OFF_W-1:0] OFF_COMMIT = 12'h524;
   localparam logic [OFF_W-1:0] OFF_ID_LO  = 12'hFD0;

   localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

   // Nine pad slots: eight contiguous words from 0x500 and one at 0x528
   localparam int unsigned N_PAD = 9;

   function automatic int unsigned pad_slot(input logic [OFF_W-1:0] a);
      if (a[1:0] != 2'b00)                    return N_PAD;
      if (a >= 12'h500 && a <= 12'h51C)       return int'(a[4:2]);
      if (a == 12'h528)                       return N_PAD - 1;
      return N_PAD;
   endfunction

   function automatic logic [7:0] id_byte(input logic [3:0] idx);
      case (idx)
         4'd4:    return 8'h61;
         4'd5:    return 8'h10;
         4'd6:    return 8'h04;
         4'd8:    return 8'h0D;
         4'd9:    return 8'hF0;
         4'd10:   return 8'h05;
         4'd11:   return 8'hB1;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_mask_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_mask_irq_cell.sv
module gpio_mask_irq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic is_input,
   input  logic sense,
   input  logic both,
   input  logic evt,
   input  logic clr,
   output logic raw
);
   logic prev;
   logic hit;

   always_comb begin
      if (sense)      hit = (lvl == evt);
      else if (both)  hit = lvl ^ prev;
      else if (evt)   hit = lvl & ~prev;
      else            hit = ~lvl & prev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         raw  <= 1'b0;
      end else begin
         prev <= lvl;
         // a new set overrides a simultaneous clear
         raw  <= (is_input & hit) | (raw & ~clr);
      end
   end
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
   import gpio_mask_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFF_W-1:0]  bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic              irq
);
   if (NPINS < 1 || NPINS > 8) begin : g_bad_npins
      $error("gpio_mask_ctrl: NPINS must be 1..8 to fit the data window");
   end
   if (DATA_W < 32) begin : g_bad_dw
      $error("gpio_mask_ctrl: DATA_W must hold the unlock key");
   end

   localparam int unsigned MASK_HI = NPINS + 1;

   logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, evt_q, mask_q, afsel_q, commit_q;
   logic [NPINS-1:0] raw_q, lvl, clr_vec, acc_mask, wd;
   logic [NPINS-1:0] pad_q [N_PAD];
   logic             locked_q;
   logic             aligned, in_data, wr_data;
   int unsigned      slot;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign in_data  = (bus_addr < OFF_DIR);
   assign acc_mask = bus_addr[MASK_HI:2];
   assign wd       = bus_wdata[NPINS-1:0];
   assign wr_data  = bus_wr && in_data;
   assign slot     = pad_slot(bus_addr);
   assign clr_vec  = (bus_wr && bus_addr == OFF_CLR) ? wd : '0;

   gpio_mask_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   for (genvar i = 0; i < int'(NPINS); i++) begin : g_pin
      gpio_mask_irq_cell u_cell (
         .clk(clk), .rst_n(rst_n), .lvl(lvl[i]), .is_input(~dir_q[i]),
         .sense(sense_q[i]), .both(both_q[i]), .evt(evt_q[i]),
         .clr(clr_vec[i]), .raw(raw_q[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      data_q[i] <= 1'b0;
         else if (!dir_q[i])              data_q[i] <= lvl[i];
         else if (wr_data && acc_mask[i]) data_q[i] <= wd[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= '0;
         sense_q  <= '0;
         both_q   <= '0;
         evt_q    <= '0;
         mask_q   <= '0;
         afsel_q  <= '0;
         commit_q <= '1;
         locked_q <= 1'b1;
         for (int p = 0; p < int'(N_PAD); p++) pad_q[p] <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            OFF_DIR:    dir_q    <= wd;
            OFF_SENSE:  sense_q  <= wd;
            OFF_BOTH:   both_q   <= wd;
            OFF_EVT:    evt_q    <= wd;
            OFF_MASK:   mask_q   <= wd;
            OFF_ALT:    afsel_q  <= (afsel_q & ~commit_q) | (wd & commit_q);
            OFF_LOCK:   locked_q <= (bus_wdata != DATA_W'(UNLOCK_KEY));
            OFF_COMMIT: if (!locked_q) commit_q <= wd;
            default: begin
               if (slot < N_PAD) pad_q[slot] <= wd;
            end
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_data) begin
         bus_rdata[NPINS-1:0] = data_q & acc_mask;
      end else if (aligned) begin
         case (bus_addr)
            OFF_DIR:    bus_rdata[NPINS-1:0] = dir_q;
            OFF_SENSE:  bus_rdata[NPINS-1:0] = sense_q;
            OFF_BOTH:   bus_rdata[NPINS-1:0] = both_q;
            OFF_EVT:    bus_rdata[NPINS-1:0] = evt_q;
            OFF_MASK:   bus_rdata[NPINS-1:0] = mask_q;
            OFF_RAW:    bus_rdata[NPINS-1:0] = raw_q;
            OFF_MSTAT:  bus_rdata[NPINS-1:0] = raw_q & mask_q;
            OFF_ALT:    bus_rdata[NPINS-1:0] = afsel_q;
            OFF_LOCK:   bus_rdata[0]         = locked_q;
            OFF_COMMIT: bus_rdata[NPINS-1:0] = commit_q;
            default: begin
               if (bus_addr >= OFF_ID_LO)
                  bus_rdata[7:0] = id_byte(bus_addr[5:2] - 4'd4);
               else if (slot < N_PAD)
                  bus_rdata[NPINS-1:0] = pad_q[slot];
            end
         endcase
      end
   end

   assign pin_out = (data_q & dir_q) | ~dir_q;
   assign irq     = |(raw_q & mask_q);
endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk
   import gpio_mask_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [OFF_W-1:0] bus_addr,
   input logic [NPINS-1:0] pin_out,
   input logic             irq,
   input logic [NPINS-1:0] data_q,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] mask_q,
   input logic [NPINS-1:0] raw_q,
   input logic [NPINS-1:0] afsel_q,
   input logic [NPINS-1:0] commit_q,
   input logic             locked_q
);
   // R3: a data write touches only output bits that are enabled by the offset
   p_data_write_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && bus_addr < OFF_DIR) |->
         (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(bus_addr[NPINS+1:2])) == '0));

   // R5: pin_out holds unless data or direction was written the previous cycle
   p_pin_out_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr && bus_addr <= OFF_DIR) |-> $stable(pin_out));

   // R7: output pins never newly set a raw status bit
   p_no_output_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & ~$past(raw_q) & $past(dir_q)) == '0));

   // R6: with no enabled bit the interrupt line stays low
   p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   // R11: commit writes while locked are dropped
   p_commit_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_COMMIT && locked_q) |=> $stable(commit_q));

   // R12: alternate-function bits outside the commit mask never change
   p_afsel_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == '0));
endmodule

bind gpio_mask_ctrl gpio_mask_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .pin_out(pin_out), .irq(irq), .data_q(data_q), .dir_q(dir_q),
   .mask_q(mask_q), .raw_q(raw_q), .afsel_q(afsel_q),
   .commit_q(commit_q), .locked_q(locked_q)
);

// File: tb/gpio_mask_ctrl_tb_top.sv
module gpio_mask_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_mask_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .irq(irq)
   );

   localparam logic [7:0] ID_EXP [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                                           8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic set_pins(input logic [7:0] p);
      @(negedge clk);
      pin_in = p;
      repeat (3) @(posedge clk);
   endtask

   function automatic logic [7:0] exp_out(input logic [7:0] d, input logic [7:0] dr);
      return (d & dr) | ~dr;
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  m_data, m_dir, pin, nd, msk, wdv;
      void'($urandom(32'h5EED_0061));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(12'h520, v); chk("R1 lock", v, 32'h1);
      rd(12'h524, v); chk("R1 commit", v, 32'hFF);
      rd(12'h400, v); chk("R1 dir", v, 32'h0);
      rd(12'h420, v); chk("R1 afsel", v, 32'h0);
      rd(12'h500, v); chk("R1 pad", v, 32'h0);
      chk("R1 pin_out", {24'h0, pin_out}, 32'hFF);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R2 R3 R4 R5 constrained random: masked data access with mixed directions
      m_data = '0; m_dir = '0; pin = '0;
      for (int it = 0; it < 60; it++) begin
         pin = 8'($urandom); set_pins(pin);
         m_data = (m_data & m_dir) | (pin & ~m_dir);
         nd = 8'($urandom); msk = 8'($urandom); wdv = 8'($urandom);
         wr(12'h400, {24'h0, nd});
         m_dir = nd;
         wr({2'b00, msk, 2'b00}, {24'h0, wdv});
         m_data = (m_data & ~(msk & m_dir)) | (wdv & msk & m_dir);
         repeat (2) @(posedge clk);
         m_data = (m_data & m_dir) | (pin & ~m_dir);
         msk = 8'($urandom);
         rd({2'b00, msk, 2'b00}, v);
         chk("R2 R3 R4 masked data", v, {24'h0, m_data & msk});
         chk("R5 pin_out", {24'h0, pin_out}, {24'h0, exp_out(m_data, m_dir)});
      end

      // R3 directed: write to input-only pins and with a zero enable field
      wr(12'h400, 32'h0F);
      wr(12'h3FC, 32'h00);
      wr(12'h000, 32'hFF);
      rd(12'h3FC, v); chk("R3 zero enable ignored", v & 32'h0F, 32'h0);
      chk("R5 inputs float high", {24'h0, pin_out}, {24'h0, 8'hF0 | 8'h00});

      // R10 pad registers with truncation
      for (int p = 0; p < 9; p++) begin
         logic [11:0] a;
         a = (p == 8) ? 12'h528 : 12'h500 + 12'(p * 4);
         wr(a, 32'h1A5 + 32'(p));
      end
      for (int p = 0; p < 9; p++) begin
         logic [11:0] a;
         a = (p == 8) ? 12'h528 : 12'h500 + 12'(p * 4);
         rd(a, v); chk("R10 pad readback", v, {24'h0, 8'(8'hA5 + 8'(p))});
      end

      // R11 R12 lock, commit, alternate function
      wr(12'h524, 32'h00); rd(12'h524, v); chk("R11 commit locked", v, 32'hFF);
      wr(12'h420, 32'hA5); rd(12'h420, v); chk("R12 afsel full commit", v, 32'hA5);
      wr(12'h520, 32'h0ACCE551); rd(12'h520, v); chk("R11 unlocked", v, 32'h0);
      wr(12'h524, 32'h0F); rd(12'h524, v); chk("R11 commit written", v, 32'h0F);
      wr(12'h520, 32'h0ACCE550); rd(12'h520, v); chk("R11 relocked", v, 32'h1);
      wr(12'h524, 32'hFF); rd(12'h524, v); chk("R11 commit held", v, 32'h0F);
      wr(12'h420, 32'h5A); rd(12'h420, v); chk("R12 afsel partial", v, 32'hAA);

      // R13 identification bytes
      for (int k = 0; k < 12; k++) begin
         rd(12'hFD0 + 12'(k * 4), v); chk("R13 id byte", v, {24'h0, ID_EXP[k]});
      end

      // R14 undefined offsets
      wr(12'h42C, 32'hFF); rd(12'h42C, v); chk("R14 undefined read", v, 32'h0);
      wr(12'h401, 32'hFF); rd(12'h400, v); chk("R14 unaligned write ignored", v, 32'h0F);
      rd(12'h600, v); chk("R14 gap read", v, 32'h0);

      // Interrupts: bit0 rising, bit1 both, bit2 level high, bit3 output, bit4 falling
      set_pins(8'h00);
      wr(12'h400, 32'h08);
      wr(12'h404, 32'h04);
      wr(12'h408, 32'h0A);
      wr(12'h40C, 32'h05);
      wr(12'h410, 32'h17);
      wr(12'h41C, 32'hFF);
      rd(12'h414, v); chk("R9 cleared start", v, 32'h0);

      set_pins(8'h01);
      rd(12'h414, v); chk("R7 rising sets", v, 32'h01);
      rd(12'h418, v); chk("R6 masked status", v, 32'h01);
      chk("R6 irq high", {31'h0, irq}, 32'h1);
      wr(12'h41C, 32'h01);
      rd(12'h414, v); chk("R9 clear", v, 32'h0);
      chk("R6 irq low", {31'h0, irq}, 32'h0);
      set_pins(8'h00);
      rd(12'h414, v); chk("R7 falling ignored on rising pin", v, 32'h0);

      set_pins(8'h02);
      rd(12'h414, v); chk("R7 both rising", v, 32'h02);
      wr(12'h41C, 32'h02);
      set_pins(8'h00);
      rd(12'h414, v); chk("R7 both falling", v, 32'h02);
      wr(12'h41C, 32'h02);

      set_pins(8'h04);
      rd(12'h414, v); chk("R8 level set", v, 32'h04);
      wr(12'h41C, 32'h04);
      rd(12'h414, v); chk("R8 level persists over clear", v, 32'h04);
      set_pins(8'h00);
      wr(12'h41C, 32'h04);
      rd(12'h414, v); chk("R8 level released", v, 32'h0);

      set_pins(8'h08); set_pins(8'h00);
      rd(12'h414, v); chk("R7 output pin no status", v, 32'h0);

      set_pins(8'h10);
      rd(12'h414, v); chk("R7 falling mode ignores rise", v, 32'h0);
      set_pins(8'h00);
      rd(12'h414, v); chk("R7 falling mode sets", v, 32'h10);
      wr(12'h41C, 32'h10);

      wr(12'h410, 32'h00);
      set_pins(8'h01);
      rd(12'h414, v); chk("R6 raw with mask off", v, 32'h01);
      rd(12'h418, v); chk("R6 masked zero", v, 32'h0);
      chk("R6 irq masked", {31'h0, irq}, 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule